// File: doc/BRIEF.md
# Decimation Period Strobe Generator

This block sets the output-word timing of a delta-sigma style converter. It keeps an 11-bit decimation setting in two byte-wide registers on a simple register bus. It counts enabled modulator clock cycles and raises a one-cycle output-word strobe at the end of every conversion period. The effective ratio is the setting plus one, and each ratio step lasts a fixed number of modulator cycles (128 by default).

Settings below a floor are treated as the floor, but only for timing. Reads return the stored value as written. The setting can be changed only while the converter is idle. When fast-filter mode is selected, an error flag shows that the effective ratio is not a multiple of 8. The converter starts running when `run` rises, and the first strobe comes one full period later.

Top module: `dps_strobe_gen`

## Requirements
- R1: The setting is SET_W (11) bits wide. Select 0 (`wr_sel`/`rd_sel` = 0) holds setting bits 7:0. Select 1 holds setting bits 10:8 in data bits 2:0. On a select-1 write, data bits 7:3 are dropped, and they read back as zero.
- R2: After reset the low register reads 0xFF and the high register reads 0x07. `word_strobe` and `fast_err` are low.
- R3: While running, a strobe comes every (S+1)·STEP_CYC enabled modulator cycles. S is the stored setting, or MIN_SET (19) when the stored setting is below MIN_SET.
- R4: The period counter advances only on cycles where `mod_ce` is high. A strobe only follows a cycle in which `mod_ce` was high.
- R5: `word_strobe` is high for exactly one clock per conversion period.
- R6: Writes made while `run` is high are ignored, and the stored setting does not change.
- R7: While `run` is low, the period count is held at zero and no strobe is produced. After `run` rises, the first strobe comes one full period later. This holds even if an earlier run was stopped partway through a period.
- R8: `fast_err` is high one clock after `fast_mode` is high and bits 2:0 of the effective (clamped) setting are not 3'b111. It is low one clock after `fast_mode` is low.
- R9: `rd_data` is registered and shows, one clock after `rd_sel`, the stored unclamped register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mod_ce | input | 1 | Modulator clock enable, one pulse per modulator cycle |
| run | input | 1 | 1 = converting, 0 = idle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write select: 0 low byte, 1 high byte |
| wr_data | input | DATA_W | Write data |
| rd_sel | input | 1 | Read select: 0 low byte, 1 high byte |
| rd_data | output | DATA_W | Registered read data |
| fast_mode | input | 1 | Fast-filter mode selected |
| word_strobe | output | 1 | One-cycle output-word strobe |
| fast_err | output | 1 | Ratio not a multiple of 8 while in fast-filter mode |

## Verification
The bench builds the block with STEP_CYC = 2 and keeps the default widths and floor. A full period at the maximum reset setting then takes 4096 cycles, so the reset setting, the clamp floor at a ratio of 20, and a high-byte setting of 256 can all be timed end to end. The same build times periods with `mod_ce` at duty cycles of 1/2, 1/3 and 1/4, so both enabled and wall-clock cycle counts are checked. It also covers clamped settings whose raw low bits are 111 but whose effective ratio still raises the fast-filter flag.

// File: rtl/dps_pkg.sv
package dps_pkg;

  // register select encoding on the byte bus
  typedef enum logic {
    SEL_LOW  = 1'b0,
    SEL_HIGH = 1'b1
  } byte_sel_e;

  // fast-filter alignment: ratio multiple of 2**FAST_BITS
  localparam int FAST_BITS = 3;

endpackage

// File: rtl/dps_regfile.sv
module dps_regfile
  import dps_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SET_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  output logic [SET_W-1:0]  setting
);

  localparam int HI_W  = SET_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;

  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic              wr_ok;
  byte_sel_e         wsel;
  byte_sel_e         rsel;

  assign wsel  = byte_sel_e'(wr_sel);
  assign rsel  = byte_sel_e'(rd_sel);
  assign wr_ok = wr_en && !run;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '1;
      hi_q <= '1;
    end else if (wr_ok) begin
      if (wsel == SEL_LOW) lo_q <= wr_data;
      else                 hi_q <= wr_data[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else if (rsel == SEL_LOW) rd_data <= lo_q;
    else rd_data <= {{PAD_W{1'b0}}, hi_q};
  end

  assign setting = {hi_q, lo_q};

endmodule

// File: rtl/dps_period_calc.sv
module dps_period_calc
  import dps_pkg::*;
#(
  parameter int SET_W   = 11,
  parameter int MIN_SET = 19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SET_W-1:0] setting,
  input  logic             fast_mode,
  output logic [SET_W-1:0] eff_set,
  output logic             fast_err
);

  localparam logic [SET_W-1:0] FLOOR = SET_W'(MIN_SET);

  always_comb begin
    if (setting < FLOOR) eff_set = FLOOR;
    else                 eff_set = setting;
  end

  always_ff @(posedge clk) begin
    if (rst) fast_err <= 1'b0;
    else     fast_err <= fast_mode && (eff_set[FAST_BITS-1:0] != '1);
  end

endmodule

// File: rtl/dps_counter.sv
module dps_counter #(
  parameter int SET_W    = 11,
  parameter int STEP_CYC = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             ce,
  input  logic [SET_W-1:0] eff_set,
  output logic             strobe
);

  logic             step_last;
  logic [SET_W-1:0] ratio_q;
  logic             ratio_last;

  generate
    if (STEP_CYC > 1) begin : g_pre
      localparam int PRE_W = $clog2(STEP_CYC);
      localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(STEP_CYC - 1);
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst || !run) pre_q <= '0;
        else if (ce)     pre_q <= (pre_q == PRE_TOP) ? '0 : pre_q + 1'b1;
      end
      assign step_last = (pre_q == PRE_TOP);
    end else begin : g_nopre
      assign step_last = 1'b1;
    end
  endgenerate

  assign ratio_last = (ratio_q == eff_set);

  always_ff @(posedge clk) begin
    if (rst || !run) ratio_q <= '0;
    else if (ce && step_last) ratio_q <= ratio_last ? '0 : ratio_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) strobe <= 1'b0;
    else     strobe <= run && ce && step_last && ratio_last;
  end

endmodule

// File: rtl/dps_strobe_gen.sv
module dps_strobe_gen #(
  parameter int DATA_W   = 8,
  parameter int SET_W    = 11,
  parameter int STEP_CYC = 128,
  parameter int MIN_SET  = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mod_ce,
  input  logic              run,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              fast_mode,
  output logic              word_strobe,
  output logic              fast_err
);

  logic [SET_W-1:0] setting_w;
  logic [SET_W-1:0] eff_w;

  dps_regfile #(.DATA_W(DATA_W), .SET_W(SET_W)) u_regs (
    .clk(clk), .rst(rst), .run(run),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .setting(setting_w)
  );

  dps_period_calc #(.SET_W(SET_W), .MIN_SET(MIN_SET)) u_calc (
    .clk(clk), .rst(rst), .setting(setting_w), .fast_mode(fast_mode),
    .eff_set(eff_w), .fast_err(fast_err)
  );

  dps_counter #(.SET_W(SET_W), .STEP_CYC(STEP_CYC)) u_cnt (
    .clk(clk), .rst(rst), .run(run), .ce(mod_ce),
    .eff_set(eff_w), .strobe(word_strobe)
  );

endmodule

// File: rtl/dps_strobe_chk.sv
module dps_strobe_chk #(
  parameter int DATA_W   = 8,
  parameter int SET_W    = 11,
  parameter int STEP_CYC = 128,
  parameter int MIN_SET  = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              run,
  input logic              mod_ce,
  input logic              wr_en,
  input logic              wr_sel,
  input logic [DATA_W-1:0] wr_data,
  input logic              fast_mode,
  input logic              word_strobe,
  input logic              fast_err,
  input logic [SET_W-1:0]  setting
);

  int gap_q;
  int exp_len;

  always_comb begin
    if (int'(setting) < MIN_SET) exp_len = (MIN_SET + 1) * STEP_CYC;
    else                         exp_len = (int'(setting) + 1) * STEP_CYC;
  end

  always_ff @(posedge clk) begin
    if (rst || !run)      gap_q <= 0;
    else if (word_strobe) gap_q <= mod_ce ? 1 : 0;
    else if (mod_ce)      gap_q <= gap_q + 1;
  end

  // R3
  period_len_chk: assert property (@(posedge clk) disable iff (rst)
    word_strobe |-> gap_q == exp_len);

  // R4
  ce_gate_chk: assert property (@(posedge clk) disable iff (rst)
    word_strobe |-> $past(mod_ce));

  // R5
  strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    word_strobe |=> !word_strobe);

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> !word_strobe);

  // R6
  write_lock_chk: assert property (@(posedge clk) disable iff (rst)
    run |=> $stable(setting));

  // R1
  low_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !run && !wr_sel) |=> setting[DATA_W-1:0] == $past(wr_data));

  // R8
  fast_off_chk: assert property (@(posedge clk) disable iff (rst)
    !fast_mode |=> !fast_err);

endmodule

bind dps_strobe_gen dps_strobe_chk #(
  .DATA_W(DATA_W), .SET_W(SET_W), .STEP_CYC(STEP_CYC), .MIN_SET(MIN_SET)
) u_chk (
  .clk(clk), .rst(rst), .run(run), .mod_ce(mod_ce),
  .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
  .fast_mode(fast_mode), .word_strobe(word_strobe), .fast_err(fast_err),
  .setting(setting_w)
);

// File: tb/tb_dps_strobe_gen.sv
module tb_dps_strobe_gen;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int SET_W      = 11;
  localparam int STEP_CYC   = 2;
  localparam int MIN_SET    = 19;
  localparam int NVEC       = 7;

  typedef struct packed {
    logic [7:0]  lo;
    logic [7:0]  hi;
    logic        fast;
    logic [7:0]  div;
    logic [15:0] period;
    logic        err;
  } vec_t;

  // expected enabled-cycle periods for STEP_CYC = 2
  localparam vec_t VECS [NVEC] = '{
    '{8'h1F, 8'h00, 1'b1, 8'd1, 16'd64,  1'b0},
    '{8'h05, 8'h00, 1'b0, 8'd3, 16'd40,  1'b0},
    '{8'h13, 8'h00, 1'b1, 8'd1, 16'd40,  1'b1},
    '{8'h14, 8'h00, 1'b0, 8'd2, 16'd42,  1'b0},
    '{8'h0F, 8'h00, 1'b1, 8'd1, 16'd40,  1'b1},
    '{8'h00, 8'h01, 1'b0, 8'd1, 16'd514, 1'b0},
    '{8'h27, 8'h00, 1'b1, 8'd4, 16'd80,  1'b0}
  };

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              mod_ce = 1'b0;
  logic              run = 1'b0;
  logic              wr_en = 1'b0;
  logic              wr_sel = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic              rd_sel = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic              fast_mode = 1'b0;
  logic              word_strobe;
  logic              fast_err;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dps_strobe_gen #(
    .DATA_W(DATA_W), .SET_W(SET_W), .STEP_CYC(STEP_CYC), .MIN_SET(MIN_SET)
  ) dut (
    .clk(clk), .rst(rst), .mod_ce(mod_ce), .run(run),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .fast_mode(fast_mode),
    .word_strobe(word_strobe), .fast_err(fast_err)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic sel, input logic [7:0] data);
    wr_en = 1'b1; wr_sel = sel; wr_data = data;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic read_reg(input logic sel, output logic [7:0] val);
    rd_sel = sel;
    tick();
    val = rd_data;
  endtask

  // runs until two strobes; returns enabled-cycle gaps and wall cycles to first
  task automatic measure(input int div, output int first, output int second,
                         output int wall, output bit double_hi);
    int cnt = 0;
    int got = 0;
    int cyc = 0;
    bit prev = 1'b0;
    first = -1; second = -1; wall = -1; double_hi = 1'b0;
    run = 1'b1;
    while (got < 2 && cyc < 20000) begin
      mod_ce = ((cyc % div) == 0);
      if (mod_ce) cnt++;
      tick();
      cyc++;
      if (word_strobe && prev) double_hi = 1'b1;
      prev = word_strobe;
      if (word_strobe) begin
        if (got == 0) begin first = cnt; wall = cyc; end
        else second = cnt;
        got++;
        cnt = 0;
      end
    end
    run = 1'b0;
    mod_ce = 1'b0;
    tick();
    tick();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    int first, second, wall;
    bit dbl;

    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R2 reset state
    check(word_strobe == 1'b0, "R2 strobe", word_strobe, 0);
    check(fast_err == 1'b0, "R2 fast_err", fast_err, 0);
    read_reg(1'b0, rv);
    check(rv == 8'hFF, "R2 low reset", rv, 8'hFF);
    read_reg(1'b1, rv);
    check(rv == 8'h07, "R2 high reset", rv, 8'h07);

    // R3 period at the reset (maximum) setting
    measure(1, first, second, wall, dbl);
    check(first == 4096, "R3 max period", first, 4096);
    check(!dbl, "R5 max single pulse", dbl, 0);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      fast_mode = VECS[i].fast;
      write_reg(1'b0, VECS[i].lo);
      write_reg(1'b1, VECS[i].hi);
      tick();
      tick();
      check(fast_err == VECS[i].err, "R8 fast flag", fast_err, VECS[i].err);
      read_reg(1'b0, rv);
      check(rv == VECS[i].lo, "R9 unclamped read", rv, VECS[i].lo);
      measure(int'(VECS[i].div), first, second, wall, dbl);
      check(first == int'(VECS[i].period), "R3 first period", first, VECS[i].period);
      check(second == int'(VECS[i].period), "R5 repeat period", second, VECS[i].period);
      check(wall == (int'(VECS[i].period) - 1) * int'(VECS[i].div) + 1,
            "R4 wall cycles", wall, (int'(VECS[i].period) - 1) * int'(VECS[i].div) + 1);
      check(!dbl, "R5 single pulse", dbl, 0);
    end

    // R8 fast mode off clears the flag
    fast_mode = 1'b1;
    write_reg(1'b0, 8'h13);
    write_reg(1'b1, 8'h00);
    tick();
    check(fast_err == 1'b1, "R8 flag set", fast_err, 1);
    fast_mode = 1'b0;
    tick();
    tick();
    check(fast_err == 1'b0, "R8 flag clear", fast_err, 0);

    // R1 high byte drops upper bits
    write_reg(1'b1, 8'hFF);
    read_reg(1'b1, rv);
    check(rv == 8'h07, "R1 high mask", rv, 8'h07);
    write_reg(1'b1, 8'h00);
    read_reg(1'b1, rv);
    check(rv == 8'h00, "R1 high write", rv, 8'h00);

    // R6 writes locked while running
    write_reg(1'b0, 8'h14);
    run = 1'b1;
    tick();
    write_reg(1'b0, 8'h40);
    write_reg(1'b1, 8'h03);
    run = 1'b0;
    tick();
    read_reg(1'b0, rv);
    check(rv == 8'h14, "R6 low locked", rv, 8'h14);
    read_reg(1'b1, rv);
    check(rv == 8'h00, "R6 high locked", rv, 8'h00);
    measure(1, first, second, wall, dbl);
    check(first == 42, "R6 period unchanged", first, 42);

    // R7 partial run then idle then restart
    run = 1'b1;
    mod_ce = 1'b1;
    repeat (30) tick();
    run = 1'b0;
    dbl = 1'b0;
    repeat (60) begin
      tick();
      if (word_strobe) dbl = 1'b1;
    end
    mod_ce = 1'b0;
    check(!dbl, "R7 idle no strobe", dbl, 0);
    measure(1, first, second, wall, dbl);
    check(first == 42, "R7 restart full period", first, 42);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule